// File: doc/BRIEF.md
# Signed/Unsigned Decimal Display Driver

This block holds a 16-bit output word and shows it in decimal on five multiplexed 14-segment character positions. Software loads the word one byte at a time. There is one write strobe for the low byte and one for the high byte, and both take their value from a shared 8-bit data input. A mode input selects how the word is read: as an unsigned number, or as a two's-complement signed number.

Each load, and each change of the mode input, starts a binary-to-decimal conversion. The conversion runs over 16 clock cycles using shift-and-add-3. The characters already on the display stay in place until the conversion completes. When it completes, the new digits are formatted:

- leading zeros are blanked;
- a minus sign is placed for negative values;
- each character is encoded as a 14-segment glyph.

A refresh divider then scans the five positions one at a time. All positions share the segment lines, and each position has its own enable.

Top module: `disp16_drv`

## Requirements
- R1: A cycle with `wr_lo_i` high loads `data_i` into bits 7:0 of the held word. Bits 15:8 keep their value unless `wr_hi_i` is also high in that cycle.
- R2: A cycle with `wr_hi_i` high loads `data_i` into bits 15:8 of the held word. Bits 7:0 keep their value unless `wr_lo_i` is also high in that cycle.
- R3: With `signed_i` low, the word is shown as an unsigned decimal from 0 to 65535. The least significant digit is at position 0, and position p is enabled by `dig_en_o[p]`.
- R4: With `signed_i` high, the word is read as two's complement. A negative value is shown as its magnitude, with the minus glyph in the position directly left of the most significant digit.
- R5: A negative value whose magnitude has five digits (-10000 to -32768) has no free position for the sign. Its position 4 therefore shows the leading digit glyph with segment bit 6 added.
- R6: Positions left of the most significant digit are blank (all segments off), apart from the minus glyph. A value of zero shows a single "0" at position 0.
- R7: Any byte write, and any change of `signed_i`, restarts the conversion. The previous characters stay on the display for at least 16 cycles after the triggering clock edge. The new characters appear no later than 20 cycles after it.
- R8: In every cycle out of reset, exactly one bit of `dig_en_o` is high. Each position stays enabled for `SCAN_DIV` cycles, the positions are visited in ascending order with wrap, and `seg_o` carries the glyph of the enabled position.
- R9: The segment map is: bit0 top, bit1 upper right, bit2 lower right, bit3 bottom, bit4 lower left, bit5 upper left, bit6 middle left, bit7 middle right, bit11 diagonal from centre to lower left. The glyph values are:

  | Character | `seg_o` |
  |---|---|
  | 0 | 003F |
  | 1 | 0006 |
  | 2 | 088B |
  | 3 | 008F |
  | 4 | 00E6 |
  | 5 | 00ED |
  | 6 | 00FD |
  | 7 | 0007 |
  | 8 | 00FF |
  | 9 | 00EF |
  | minus | 00C0 |
  | blank | 0000 |

- R10: After reset, the held word is 0 and the display shows "0".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Byte to be written |
| wr_lo_i | input | 1 | Low-byte write strobe |
| wr_hi_i | input | 1 | High-byte write strobe |
| signed_i | input | 1 | 1: two's-complement view, 0: unsigned view |
| seg_o | output | 14 | Segment lines of the enabled position |
| dig_en_o | output | 5 | One-hot position enables |

## Verification
The hardest case to reach from the ports is the hold window. This is the stretch of cycles in which a new word is already in the register but the display must still show the old characters. To reach it, the bench sets a scan divider of two, so a full frame fits inside the 16 conversion cycles. After each write, the scoreboard first expects the previous frame and then the new one. The bench also restarts a conversion with no write at all, by flipping `signed_i` alone. Five-digit negatives, including -32768, exercise the merged sign glyph.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned SEG_W = 14;
  localparam logic [3:0] SYM_BLANK = 4'hA;
  localparam logic [3:0] SYM_MINUS = 4'hB;

  typedef struct packed {
    logic       mark;  // add left-middle bar (merged sign)
    logic [3:0] sym;
  } cell_t;

  function automatic logic [SEG_W-1:0] glyph(cell_t c);
    logic [SEG_W-1:0] g;
    case (c.sym)
      4'd0:      g = 14'h003F;
      4'd1:      g = 14'h0006;
      4'd2:      g = 14'h088B;
      4'd3:      g = 14'h008F;
      4'd4:      g = 14'h00E6;
      4'd5:      g = 14'h00ED;
      4'd6:      g = 14'h00FD;
      4'd7:      g = 14'h0007;
      4'd8:      g = 14'h00FF;
      4'd9:      g = 14'h00EF;
      SYM_MINUS: g = 14'h00C0;
      default:   g = 14'h0000;
    endcase
    if (c.mark) g[6] = 1'b1;
    return g;
  endfunction
endpackage

// File: rtl/dd_conv.sv
module dd_conv
  import disp_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned N = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     word_i,
  input  logic             signed_i,
  output cell_t [N-1:0]    disp_o
);
  localparam int unsigned BW = 4 * N;
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] bcd_q, adj;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q, neg_q;
  cell_t [N-1:0] disp_q, fmt;

  always_comb begin
    for (int i = 0; i < N; i++)
      adj[4*i +: 4] = (bcd_q[4*i +: 4] >= 4'd5) ? bcd_q[4*i +: 4] + 4'd3 : bcd_q[4*i +: 4];
  end

  always_comb begin
    int msd;
    msd = 0;
    for (int i = 0; i < N; i++)
      if (bcd_q[4*i +: 4] != 4'd0) msd = i;
    for (int i = 0; i < N; i++) begin
      fmt[i].mark = 1'b0;
      fmt[i].sym  = (i <= msd) ? bcd_q[4*i +: 4] : SYM_BLANK;
      if (neg_q && i == msd + 1) fmt[i].sym = SYM_MINUS;
    end
    if (neg_q && msd == N - 1) fmt[N-1].mark = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        neg_q  <= signed_i & word_i[W-1];
        sh_q   <= (signed_i & word_i[W-1]) ? ~word_i + 1'b1 : word_i;
        bcd_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        {bcd_q, sh_q} <= {adj, sh_q} << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        disp_q[i] <= (i == 0) ? cell_t'{1'b0, 4'd0} : cell_t'{1'b0, SYM_BLANK};
    end else if (fin_q) begin
      disp_q <= fmt;
    end
  end

  assign disp_o = disp_q;

  function automatic logic bcd_ok(logic [BW-1:0] b);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (b[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_BCD_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> bcd_ok(bcd_q)); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && cnt_q == CW'(W)); // R7
endmodule

// File: rtl/dd_scan.sv
module dd_scan
  import disp_pkg::*;
#(
  parameter int unsigned N   = 5,
  parameter int unsigned DIV = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cell_t [N-1:0]      disp_i,
  output logic [SEG_W-1:0]   seg_o,
  output logic [N-1:0]       dig_en_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

  logic [DW-1:0] div_q;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_q <= '0;
    end else if (div_q == DW'(DIV - 1)) begin
      div_q  <= '0;
      slot_q <= (slot_q == SW'(N - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign dig_en_o = N'(1) << slot_q;
  assign seg_o    = glyph(disp_i[slot_q]);

  AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dig_en_o) == 1); // R8
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SW'(N)); // R8
endmodule

// File: rtl/disp16_drv.sv
module disp16_drv
  import disp_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned N_DIG    = 5,
  parameter int unsigned SCAN_DIV = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               signed_i,
  output logic [SEG_W-1:0]   seg_o,
  output logic [N_DIG-1:0]   dig_en_o
);
  localparam int unsigned W = 2 * BYTE_W;

  logic [W-1:0]  word_q;
  logic          mode_q, start_q;
  cell_t [N_DIG-1:0] disp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      mode_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (wr_lo_i) word_q[BYTE_W-1:0] <= data_i;
      if (wr_hi_i) word_q[W-1:BYTE_W] <= data_i;
      mode_q  <= signed_i;
      start_q <= wr_lo_i | wr_hi_i | (signed_i != mode_q);
    end
  end

  dd_conv #(.W(W), .N(N_DIG)) u_conv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_q),
    .word_i   (word_q),
    .signed_i (mode_q),
    .disp_o   (disp)
  );

  dd_scan #(.N(N_DIG), .DIV(SCAN_DIV)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .disp_i   (disp),
    .seg_o    (seg_o),
    .dig_en_o (dig_en_o)
  );

  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> word_q[W-1:BYTE_W] == $past(word_q[W-1:BYTE_W])); // R1
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> word_q[BYTE_W-1:0] == $past(word_q[BYTE_W-1:0])); // R2
endmodule

// File: tb/disp16_drv_bench.sv
module disp16_drv_bench;
  localparam int DIV = 2;
  localparam int ND  = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        wr_lo_i = 1'b0, wr_hi_i = 1'b0, signed_i = 1'b0;
  logic [13:0] seg_o;
  logic [4:0]  dig_en_o;

  int checks = 0, errors = 0;
  logic [69:0] exp_q[$];
  string       tag_q[$];
  logic        mon_busy = 1'b0;
  logic [15:0] m_word = '0;
  logic        m_mode = 1'b0;
  logic [69:0] cur_frame;

  always #5 clk = ~clk;

  disp16_drv #(.SCAN_DIV(DIV)) u_disp16_drv (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .wr_lo_i(wr_lo_i),
    .wr_hi_i(wr_hi_i), .signed_i(signed_i), .seg_o(seg_o), .dig_en_o(dig_en_o)
  );

  function automatic logic [13:0] font(int d);
    case (d)
      0: return 14'h003F; 1: return 14'h0006; 2: return 14'h088B;
      3: return 14'h008F; 4: return 14'h00E6; 5: return 14'h00ED;
      6: return 14'h00FD; 7: return 14'h0007; 8: return 14'h00FF;
      default: return 14'h00EF;
    endcase
  endfunction

  // R3 R4 R5 R6 R9: expected frame from value and mode
  function automatic logic [69:0] frame(logic [15:0] w, logic sm);
    logic [69:0] f;
    logic neg;
    int mag, msd;
    int d[ND];
    neg = sm & w[15];
    mag = neg ? 65536 - int'(w) : int'(w);
    for (int i = 0; i < ND; i++) begin d[i] = mag % 10; mag = mag / 10; end
    msd = 0;
    for (int i = 0; i < ND; i++) if (d[i] != 0) msd = i;
    for (int i = 0; i < ND; i++) begin
      logic [13:0] g;
      g = 14'h0;
      if (i <= msd) g = font(d[i]);
      if (neg && i == msd + 1) g = 14'h00C0;
      if (neg && msd == ND - 1 && i == ND - 1) g = g | 14'h0040;
      f[i*14 +: 14] = g;
    end
    return f;
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(logic cond, string tag, string what, int act, int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected frame and observes one full scan
  initial begin
    forever begin
      logic [69:0] e;
      logic [69:0] got;
      logic [4:0]  seen;
      logic        oh_ok;
      string       t;
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = '0; seen = '0; oh_ok = 1'b1;
      for (int k = 0; k < ND * DIV; k++) begin
        @(negedge clk);
        if ($countones(dig_en_o) != 1) oh_ok = 1'b0;
        for (int p = 0; p < ND; p++)
          if (dig_en_o[p]) begin got[p*14 +: 14] = seg_o; seen[p] = 1'b1; end
      end
      check(oh_ok && seen == 5'h1F, "R8", "one-hot scan coverage", int'(seen), 32'h1F);
      for (int p = 0; p < ND; p++)
        check(got[p*14 +: 14] == e[p*14 +: 14], t, $sformatf("pos%0d", p),
              int'(got[p*14 +: 14]), int'(e[p*14 +: 14]));
      mon_busy = 1'b0;
    end
  end

  task automatic expect_frame(logic [69:0] f, string tag);
    exp_q.push_back(f);
    tag_q.push_back(tag);
    #1;
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // driver: write, expect old frame during conversion (R7), then new frame
  task automatic apply(logic lo, logic hi, logic [7:0] d, logic sm, string tag);
    logic [69:0] prev;
    prev = cur_frame;
    @(negedge clk);
    data_i = d; wr_lo_i = lo; wr_hi_i = hi; signed_i = sm;
    @(posedge clk);
    @(negedge clk);
    wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    if (lo) m_word[7:0] = d;
    if (hi) m_word[15:8] = d;
    m_mode = sm;
    expect_frame(prev, "R7");
    repeat (12) @(negedge clk);
    cur_frame = frame(m_word, m_mode);
    expect_frame(cur_frame, tag);
  endtask

  task automatic load16(logic [15:0] w, logic sm, string tag);
    apply(1'b0, 1'b1, w[15:8], sm, tag);
    apply(1'b1, 1'b0, w[7:0], sm, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cur_frame = frame(16'h0, 1'b0);
    expect_frame(cur_frame, "R10");
    // R1 R2: byte-wise loads keep the other half
    apply(1'b0, 1'b1, 8'h12, 1'b0, "R2");   // 0x1200 = 4608
    apply(1'b1, 1'b0, 8'h34, 1'b0, "R1");   // 0x1234 = 4660
    apply(1'b1, 1'b0, 8'hFF, 1'b0, "R1");   // 0x12FF
    apply(1'b0, 1'b1, 8'h00, 1'b0, "R2");   // 0x00FF = 255
    apply(1'b1, 1'b1, 8'hFF, 1'b0, "R3");   // both strobes: 65535
    // R7: mode flip alone restarts conversion -> -1 (R4)
    apply(1'b0, 1'b0, 8'h00, 1'b1, "R4");
    load16(16'h0000, 1'b1, "R6");
    load16(16'd7, 1'b0, "R6");
    load16(16'h8000, 1'b1, "R5");           // -32768
    apply(1'b0, 1'b0, 8'h00, 1'b0, "R3");   // 32768 unsigned
    load16(16'h7FFF, 1'b1, "R4");           // 32767
    load16(16'hFF9C, 1'b1, "R4");           // -100
    load16(-16'sd12345, 1'b1, "R5");        // -12345
    load16(16'hFFF6, 1'b1, "R4");           // -10
    load16(16'd10203, 1'b0, "R9");
    load16(16'd98765, 1'b0, "R9");          // truncated to 16 bits = 33229
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule